// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the lookup controller of a small two-way set-associative read cache. Each set has a one-bit prediction entry. The entry names the way that is probed first. When the predicted way holds the requested line, the data returns on the cycle after the request is taken. When it does not, the other way is probed on the following cycle. A hit found there is reported as a slow hit, and the prediction entry is turned to point at that way.

When neither way holds the line, the block raises a refill request to the next memory level and waits for the returned word. It writes that word into a chosen way and forwards it to the requester in the same cycle. The prediction entry is then set to the freshly filled way.

Lines are one data word wide. The low address bits select the set and the remaining upper bits form the tag. The block accepts one request at a time. A request may be presented in the same cycle that the previous response leaves, so fast hits can stream back to back.

Top module: `waypred_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `fill_req_valid` are 0, and every line is invalid, so the first access to any address misses.
- R2: The set index and the prediction entry are selected by address bits [IDX_W-1:0]. The tag is address bits [ADDR_W-1:IDX_W]. Two addresses with equal tags but different index bits never hit on each other's lines.
- R3: When the predicted way holds the line, `rsp_valid` is 1 on the cycle after acceptance, with `rsp_slow`=0, `rsp_miss`=0 and the stored data.
- R4: When only the non-predicted way holds the line, `rsp_valid` is 1 two cycles after acceptance, with `rsp_slow`=1 and the stored data. The set's prediction then points at that way, so an immediate repeat of the access is fast.
- R5: When both ways miss, `fill_req_valid` rises three cycles after acceptance with `fill_req_addr` equal to the request address. Both are held until `fill_rsp_valid`. In that cycle `rsp_valid`=1, `rsp_miss`=1 and `rsp_data` equals `fill_rsp_data`.
- R6: After a refill, the set's prediction points at the filled way, so an immediate repeat of the access is a fast hit.
- R7: A refill goes to the non-predicted way if that way is invalid. Otherwise it goes to the set's least recently used way, where "used" means hit or filled.
- R8: `req_ready` is 0 during the second probe and throughout a refill. A request offered then is ignored, and the outstanding lookup keeps its own address.
- R9: A fast hit leaves the prediction entry unchanged.
- R10: `req_ready` is 1 in every response cycle, so a new request can be taken in the same cycle that the previous response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address (tag and index) |
| req_ready | output | 1 | Request is taken when high together with `req_valid` |
| rsp_valid | output | 1 | Response data valid this cycle |
| rsp_data | output | DATA_W | Response data |
| rsp_slow | output | 1 | Response came from the non-predicted way |
| rsp_miss | output | 1 | Response came from a refill |
| fill_req_valid | output | 1 | Refill request to the next level |
| fill_req_addr | output | ADDR_W | Address to refill |
| fill_rsp_valid | input | 1 | Refill data present |
| fill_rsp_data | input | DATA_W | Refill data |

## Verification
Every set of an eight-set configuration is driven with the same access pattern over three tags that collide in that set. The pattern is cold misses into both ways, a hit in the wrong way, a repeat of that access, an alternate line, then a third tag that forces an eviction, and finally a return to the evicted tags. Each access therefore lands as a fast hit, a slow hit or a miss. The expected class is taken from a model of the prediction and LRU bits kept in the bench, so latency errors, wrong victim choices and missing prediction updates each show up as a different mismatch. Separate cases use different fill latencies, requests offered while the block is busy, addresses that share a tag across sets, and two fast hits issued back to back.

// File: rtl/waypred_pkg.sv
package waypred_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE1 = 2'd1,
    ST_PROBE2 = 2'd2,
    ST_FILL   = 2'd3
  } look_state_t;

  // way to refill: the alternate way if empty, else the LRU way (R7)
  function automatic logic pick_victim(input logic pred_way,
                                       input logic alt_valid,
                                       input logic lru_way);
    return alt_valid ? lru_way : ~pred_way;
  endfunction
endpackage

// File: rtl/waypred_pred_table.sv
module waypred_pred_table #(
  parameter int SETS  = 8,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             pred_way,
  output logic             lru_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way
);
  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] lru_q;

  assign pred_way = pred_q[rd_idx];
  assign lru_way  = lru_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      lru_q  <= '0;
    end else begin
      if (upd_en)   pred_q[upd_idx]   <= upd_way;
      if (touch_en) lru_q[touch_idx]  <= ~touch_way;
    end
  end
endmodule

// File: rtl/waypred_way_store.sv
module waypred_way_store #(
  parameter int SETS   = 8,
  parameter int IDX_W  = $clog2(SETS),
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/waypred_cache.sv
module waypred_cache
  import waypred_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_slow,
  output logic              rsp_miss,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [DATA_W-1:0] fill_rsp_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  look_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              victim_q;

  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              pred_way, lru_way, probe_way;
  logic [1:0]        way_valid;
  logic [TAG_W-1:0]  way_tag  [2];
  logic [DATA_W-1:0] way_data [2];
  logic [1:0]        way_wr;

  // named internal events
  logic accept, probe_hit, fast_hit, slow_hit, fill_done, both_miss;

  assign cur_idx   = idx_of(addr_q);
  assign cur_tag   = tag_of(addr_q);
  assign probe_way = (state_q == ST_PROBE2) ? ~pred_way : pred_way;
  assign probe_hit = way_valid[probe_way] && (way_tag[probe_way] == cur_tag);
  assign fast_hit  = (state_q == ST_PROBE1) && probe_hit;
  assign slow_hit  = (state_q == ST_PROBE2) && probe_hit;
  assign both_miss = (state_q == ST_PROBE2) && !probe_hit;
  assign fill_done = (state_q == ST_FILL) && fill_rsp_valid;

  assign rsp_valid = fast_hit || slow_hit || fill_done;
  assign rsp_data  = fill_done ? fill_rsp_data : way_data[probe_way];
  assign rsp_slow  = slow_hit;
  assign rsp_miss  = fill_done;
  assign req_ready = (state_q == ST_IDLE) || rsp_valid;
  assign accept    = req_valid && req_ready;

  assign fill_req_valid = (state_q == ST_FILL);
  assign fill_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      victim_q <= 1'b0;
    end else begin
      if (accept) begin
        state_q <= ST_PROBE1;
        addr_q  <= req_addr;
      end else if (rsp_valid) begin
        state_q <= ST_IDLE;
      end else if (state_q == ST_PROBE1) begin
        state_q <= ST_PROBE2;
      end else if (both_miss) begin
        state_q  <= ST_FILL;
        victim_q <= pick_victim(pred_way, way_valid[~pred_way], lru_way);
      end
    end
  end

  waypred_pred_table #(.SETS(SETS), .IDX_W(IDX_W)) pred_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (cur_idx),
    .pred_way  (pred_way),
    .lru_way   (lru_way),
    .upd_en    (slow_hit || fill_done),
    .upd_idx   (cur_idx),
    .upd_way   (fill_done ? victim_q : probe_way),
    .touch_en  (rsp_valid),
    .touch_idx (cur_idx),
    .touch_way (fill_done ? victim_q : probe_way)
  );

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_wr[w] = fill_done && (victim_q == 1'(w));
    waypred_way_store #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (cur_idx),
      .rd_valid (way_valid[w]),
      .rd_tag   (way_tag[w]),
      .rd_data  (way_data[w]),
      .wr_en    (way_wr[w]),
      .wr_idx   (cur_idx),
      .wr_tag   (cur_tag),
      .wr_data  (fill_rsp_data)
    );
  end

  // a fast response comes only one cycle after an acceptance (R3)
  p_fast_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_slow && !rsp_miss) |-> $past(accept));

  // a slow response comes two cycles after acceptance, none in between (R4)
  p_slow_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_slow |-> ($past(accept, 2) && !$past(accept)));

  // refill request and its address hold until the data returns (R5)
  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr)));

  // no request is taken while a refill is outstanding (R8)
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_rsp_valid) |-> !req_ready);

  // every response cycle also offers acceptance (R10)
  p_ready_on_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

// File: tb/waypred_cache_tb.sv
module waypred_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int SETS   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_slow;
  logic              rsp_miss;
  logic              fill_req_valid;
  logic [ADDR_W-1:0] fill_req_addr;
  logic              fill_rsp_valid = 1'b0;
  logic [DATA_W-1:0] fill_rsp_data = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  waypred_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_slow(rsp_slow), .rsp_miss(rsp_miss),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
  );

  // bench model: per set, two ways of (valid, tag), a predicted way, an LRU way
  bit m_valid [SETS][2];
  int m_tag   [SETS][2];
  bit m_pred  [SETS];
  bit m_lru   [SETS];

  function automatic logic [DATA_W-1:0] fdata(input int a);
    return DATA_W'((a * 257 + 77) % 65536);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 = fast hit, 1 = slow hit, 2 = miss; updates the model
  function automatic int model_step(input int a);
    int s = a % SETS;
    int t = a / SETS;
    bit p = m_pred[s];
    bit v;
    if (m_valid[s][p] && m_tag[s][p] == t) begin
      m_lru[s] = !p;                 // R9: prediction left alone
      return 0;
    end
    if (m_valid[s][!p] && m_tag[s][!p] == t) begin
      m_pred[s] = !p;                // R4
      m_lru[s]  = p;
      return 1;
    end
    v = m_valid[s][!p] ? m_lru[s] : !p;  // R7
    m_valid[s][v] = 1'b1;
    m_tag[s][v]   = t;
    m_pred[s]     = v;               // R6
    m_lru[s]      = !v;
    return 2;
  endfunction

  task automatic access(input int a, input int dly, input bit junk);
    int kind = model_step(a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    @(negedge clk);
    if (kind == 0) begin
      req_valid = 1'b0;
      check(rsp_valid && !rsp_slow && !rsp_miss, "R3 fast hit flags", {rsp_valid, rsp_slow, rsp_miss}, 3'b100);
      check(rsp_data == fdata(a), "R3 fast hit data", rsp_data, fdata(a));
      check(req_ready, "R10 ready on fast response", req_ready, 1);
      return;
    end
    req_valid = junk;                       // R8: offered while busy
    req_addr  = ADDR_W'(a ^ 8'h5A);
    check(!rsp_valid && !req_ready, "R8 busy after first probe miss", {rsp_valid, req_ready}, 0);
    @(negedge clk);
    if (kind == 1) begin
      req_valid = 1'b0;
      check(rsp_valid && rsp_slow && !rsp_miss, "R4 slow hit flags", {rsp_valid, rsp_slow, rsp_miss}, 3'b110);
      check(rsp_data == fdata(a), "R4 slow hit data", rsp_data, fdata(a));
      return;
    end
    check(!rsp_valid && !req_ready, "R8 busy in second probe", {rsp_valid, req_ready}, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(fill_req_valid && fill_req_addr == ADDR_W'(a), "R5 refill request and address",
          fill_req_addr, a);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(fill_req_valid && !rsp_valid && !req_ready, "R5 refill held",
            {fill_req_valid, rsp_valid, req_ready}, 3'b100);
    end
    fill_rsp_valid = 1'b1;
    fill_rsp_data  = fdata(a);
    #1;
    check(rsp_valid && rsp_miss && !rsp_slow, "R5 miss response flags (victim per R7)",
          {rsp_valid, rsp_slow, rsp_miss}, 3'b101);
    check(rsp_data == fdata(a), "R5 miss response data", rsp_data, fdata(a));
    @(negedge clk);
    fill_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 1'b0;
      m_lru[s]  = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_valid[s][w] = 1'b0;
        m_tag[s][w]   = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !rsp_valid && !fill_req_valid, "R1 reset outputs",
          {req_ready, rsp_valid, fill_req_valid}, 3'b100);

    // R1 cold miss; R2 same tag, different index stays separate; R6 refill then fast
    access(8, 0, 1'b0);
    access(9, 1, 1'b0);
    access(8, 0, 1'b0);
    access(9, 0, 1'b0);

    // sweep every set with three colliding tags
    for (int s = 0; s < SETS; s++) begin
      int a = (s + 1) * SETS + s;
      int b = (s + 9) * SETS + s;
      int c = (s + 17) * SETS + s;
      access(a, s % 3, 1'b1);
      access(b, (s + 1) % 3, 1'b0);
      access(a, 0, 1'b1);
      access(a, 0, 1'b0);
      access(b, 0, 1'b0);
      access(c, s % 2, 1'b1);
      access(a, 2, 1'b0);
      access(c, 0, 1'b0);
      access(b, 1, 1'b0);
    end

    // R10: two fast hits back to back
    begin
      int x = 21 * SETS + 5;
      int y = 22 * SETS + 6;
      int kx, ky;
      access(x, 0, 1'b0);
      access(y, 0, 1'b0);
      kx = model_step(x);
      ky = model_step(y);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = ADDR_W'(x);
      @(negedge clk);
      check(kx == 0 && rsp_valid && !rsp_slow && rsp_data == fdata(x) && req_ready,
            "R10 first of back-to-back", rsp_data, fdata(x));
      req_addr = ADDR_W'(y);
      @(negedge clk);
      req_valid = 1'b0;
      check(ky == 0 && rsp_valid && !rsp_slow && !rsp_miss && rsp_data == fdata(y),
            "R10 second of back-to-back", rsp_data, fdata(y));
    end

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule